// File: doc/BRIEF.md
# Strip Readout Chip Sequencer

This block runs the readout of a chain of front-end analog chips that sit on one silicon strip module. Each chip holds a sample-and-hold value for each of its channels and shifts them out one at a time. When the trigger line pulses, the sequencer waits a settable delay so that the shaper output reaches its peak. It then closes the hold, waits a short settle gap, and passes a token into the chain. After that it issues one readout clock per channel. On each readout clock it gives the downstream ADC a sample strobe and the global strip number.

A busy line toward the trigger processor covers the whole event. A trigger that arrives while busy is high is dropped and counted. The sequencer accepts a per-chip skip mask, so chips that are left out of the chain receive no clocks and their strip range does not appear. A fast-clear request during the settle gap aborts the event. A test-pulse request is passed on to the chips only while the sequencer is idle.

Top module: `strip_seq`

## Requirements
- R1: After reset, busy, hold, token, readout clock, sample-valid, fast-clear and test outputs are 0, and the rejected-trigger count is 0.
- R2: A trigger seen while idle raises busy in the next cycle. The skip mask and the hold delay D are captured at that edge.
- R3: Hold rises after the busy line has been high for D cycles, where D is at least 1. Hold stays high until the last sample has been issued.
- R4: After TOK_GAP cycles of hold, the readout clock and sample-valid are high for one cycle per channel of each chip that is not skipped, with no gaps between them. Token is high only on the first of these cycles.
- R5: During the readout, the strip index equals chip × CH_PER_CHIP + channel. Chips are visited in ascending order, channel 0 first within each chip.
- R6: A chip whose skip-mask bit is 1 gets no readout clocks, and its index range is left out. If every chip is skipped, no sample is issued and busy drops right after the settle gap.
- R7: Busy and hold fall in the cycle after the last sample.
- R8: A trigger seen while busy is high does not change the ongoing sequence. It adds one to the rejected-trigger count, which wraps modulo 2^REJW.
- R9: A fast-clear request during the settle gap has the following effect from the next cycle: hold drops, the fast-clear output stays high for FC_LEN cycles while busy stays high, and then busy falls and the sequencer returns to idle without any sample.
- R10: A fast-clear request during the hold delay has no effect on the sequence.
- R11: The test output equals the test request while the sequencer is idle, and is 0 while busy is high.
- R12: Changes to the skip mask or to the delay input after a trigger has been accepted do not affect that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger pulse |
| fclr_req_i | input | 1 | Fast-clear request |
| test_req_i | input | 1 | Test-pulse request |
| hold_dly_i | input | DLYW | Hold delay D in cycles, captured at trigger |
| skip_i | input | N_CHIPS | Per-chip skip mask, 1 = skip, captured at trigger |
| busy_o | output | 1 | Busy toward the trigger processor |
| fe_hold_o | output | 1 | Sample-and-hold freeze to the chips |
| fe_clk_o | output | 1 | Readout clock pulse to the chips |
| fe_token_o | output | 1 | Token injected at the start of the chain |
| fe_fclr_o | output | 1 | Fast clear to the chips |
| fe_test_o | output | 1 | Test pulse to the chips |
| smp_valid_o | output | 1 | Sample strobe to the ADC |
| strip_o | output | $clog2(N_CHIPS*CH_PER_CHIP) | Strip index of the current sample |
| rej_cnt_o | output | REJW | Rejected-trigger count |

## Verification
Every one of the 16 skip masks of a four-chip, four-channel chain is run at hold delays of 1, 3 and 7. This shows whether the index jumps land on the correct chip boundaries, and whether an all-skipped chain ends cleanly and a fully enabled chain runs to its full length. In some runs an extra trigger is injected during the event. In all runs the mask and delay inputs are changed after acceptance. These two stimuli separate genuine capture and rejection from behaviour that follows the live inputs. Fast-clear requests are placed inside the settle gap and inside the delay, which shows whether the abort window has the correct bounds.

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int N_CHIPS     = 12,
  parameter int CH_PER_CHIP = 128,
  parameter int DLYW        = 4,
  parameter int TOK_GAP     = 2,
  parameter int FC_LEN      = 2,
  parameter int REJW        = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      trig_i,
  input  logic                                      fclr_req_i,
  input  logic                                      test_req_i,
  input  logic [DLYW-1:0]                           hold_dly_i,
  input  logic [N_CHIPS-1:0]                        skip_i,
  output logic                                      busy_o,
  output logic                                      fe_hold_o,
  output logic                                      fe_clk_o,
  output logic                                      fe_token_o,
  output logic                                      fe_fclr_o,
  output logic                                      fe_test_o,
  output logic                                      smp_valid_o,
  output logic [$clog2(N_CHIPS*CH_PER_CHIP)-1:0]    strip_o,
  output logic [REJW-1:0]                           rej_cnt_o
);
  localparam int SW  = $clog2(N_CHIPS*CH_PER_CHIP);
  localparam int CIW = $clog2(N_CHIPS+1);
  localparam int CHW = (CH_PER_CHIP > 1) ? $clog2(CH_PER_CHIP) : 1;
  localparam int CW  = DLYW + 3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ARM, S_SHIFT, S_CLEAR} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [DLYW-1:0]   dly_q;
  logic [N_CHIPS-1:0] skip_q;
  logic [CIW-1:0]    chip_q;
  logic [CHW-1:0]    ch_q;
  logic [SW-1:0]     strip_q;
  logic              first_q;
  logic [REJW-1:0]   rej_q;
  int                nxt_first, nxt_after;

  function automatic int next_live(input logic [N_CHIPS-1:0] m, input int from);
    int r;
    r = N_CHIPS;
    for (int i = N_CHIPS-1; i >= 0; i--)
      if (i >= from && !m[i]) r = i;
    return r;
  endfunction

  always_comb begin
    nxt_first = next_live(skip_q, 0);
    nxt_after = next_live(skip_q, int'(chip_q) + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      dly_q   <= '0;
      skip_q  <= '0;
      chip_q  <= '0;
      ch_q    <= '0;
      strip_q <= '0;
      first_q <= 1'b0;
      rej_q   <= '0;
    end else begin
      if (trig_i && st != S_IDLE) rej_q <= rej_q + REJW'(1);
      case (st)
        S_IDLE: if (trig_i) begin
          st     <= S_WAIT;
          cnt    <= CW'(1);
          dly_q  <= hold_dly_i;
          skip_q <= skip_i;
        end
        S_WAIT: if (cnt >= CW'(dly_q)) begin
          st  <= S_ARM;
          cnt <= CW'(1);
        end else cnt <= cnt + CW'(1);
        S_ARM: if (fclr_req_i) begin
          st  <= S_CLEAR;
          cnt <= CW'(1);
        end else if (cnt >= CW'(TOK_GAP)) begin
          if (nxt_first < N_CHIPS) begin
            st      <= S_SHIFT;
            chip_q  <= CIW'(nxt_first);
            ch_q    <= '0;
            strip_q <= SW'(nxt_first * CH_PER_CHIP);
            first_q <= 1'b1;
          end else st <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_SHIFT: begin
          first_q <= 1'b0;
          if (ch_q == CHW'(CH_PER_CHIP-1)) begin
            if (nxt_after < N_CHIPS) begin
              chip_q  <= CIW'(nxt_after);
              ch_q    <= '0;
              strip_q <= SW'(nxt_after * CH_PER_CHIP);
            end else st <= S_IDLE;
          end else begin
            ch_q    <= ch_q + CHW'(1);
            strip_q <= strip_q + SW'(1);
          end
        end
        S_CLEAR: if (cnt >= CW'(FC_LEN)) st <= S_IDLE;
                 else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st != S_IDLE);
  assign fe_hold_o   = (st == S_ARM) || (st == S_SHIFT);
  assign smp_valid_o = (st == S_SHIFT);
  assign fe_clk_o    = smp_valid_o;
  assign fe_token_o  = smp_valid_o && first_q;
  assign fe_fclr_o   = (st == S_CLEAR);
  assign fe_test_o   = (st == S_IDLE) && test_req_i;
  assign strip_o     = strip_q;
  assign rej_cnt_o   = rej_q;

  // R8
  rej_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> rej_cnt_o == $past(rej_cnt_o) + REJW'(1));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(smp_valid_o) || $past(fe_fclr_o) || $past(fe_hold_o)));
  // R5
  strip_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && $past(smp_valid_o)) |-> strip_o > $past(strip_o));
  // R3
  hold_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> (fe_hold_o && busy_o));
  // R9
  fclr_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_fclr_o |-> (!fe_hold_o && busy_o));
  // R4
  token_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_token_o |-> !$past(smp_valid_o));
endmodule

// File: tb/strip_seq_test.sv
module strip_seq_test;
  localparam int N = 4, CH = 4, DW = 3, G = 2, FC = 2, RW = 8;
  localparam int SW = $clog2(N*CH);

  logic clk = 0, rst_n = 0, trig = 0, fclr = 0, treq = 0;
  logic [DW-1:0] dly = 0;
  logic [N-1:0]  skip = 0;
  logic busy, hold, fck, tok, fco, tst, vld;
  logic [SW-1:0] strip;
  logic [RW-1:0] rej;
  int pass_n = 0, tot_n = 0;

  always #2 clk = ~clk;

  strip_seq #(.N_CHIPS(N), .CH_PER_CHIP(CH), .DLYW(DW), .TOK_GAP(G), .FC_LEN(FC), .REJW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .fclr_req_i(fclr), .test_req_i(treq),
    .hold_dly_i(dly), .skip_i(skip), .busy_o(busy), .fe_hold_o(hold), .fe_clk_o(fck),
    .fe_token_o(tok), .fe_fclr_o(fco), .fe_test_o(tst), .smp_valid_o(vld),
    .strip_o(strip), .rej_cnt_o(rej));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tot_n++;
    if (ok) pass_n++;
    else $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic run(input logic [N-1:0] m, input int d, input bit extra);
    int en[$];
    int s, last, r0, j;
    for (int i = 0; i < N; i++) if (!m[i]) en.push_back(i);
    s = en.size() * CH;
    last = d + G + s;
    r0 = int'(rej);
    @(negedge clk); trig = 1; skip = m; dly = DW'(d);
    for (int n = 1; n <= last + 1; n++) begin
      @(negedge clk);
      trig = 0;
      if (n == 1) begin skip = ~m; dly = 0; end
      if (n == 1) eq("R2 busy after trigger", int'(busy), 1);
      eq("R7 busy window", int'(busy), int'(n <= last));
      eq("R3 hold window", int'(hold), int'(n > d && n <= last));
      eq("R4 sample window", int'(vld), int'(n > d + G && n <= last));
      eq("R4 clock equals strobe", int'(fck), int'(n > d + G && n <= last));
      eq("R4 token", int'(tok), int'(n == d + G + 1 && s > 0));
      eq("R9 no stray fast clear", int'(fco), 0);
      if (n > d + G && n <= last) begin
        j = n - d - G - 1;
        eq("R5 R6 R12 strip index", int'(strip), en[j / CH] * CH + j % CH);
      end
      trig = extra && (n == d + 1);
    end
    trig = 0;
    eq("R8 rejected count", int'(rej), (r0 + (extra ? 1 : 0)) % (1 << RW));
  endtask

  task automatic abort(input int d, input int at);
    int n_clr;
    @(negedge clk); trig = 1; skip = 0; dly = DW'(d);
    @(negedge clk); trig = 0;
    for (int n = 1; n < at; n++) @(negedge clk);
    fclr = 1;
    @(negedge clk); fclr = 0;
    if (at > d) begin
      n_clr = 0;
      for (int k = 0; k < FC; k++) begin
        eq("R9 fast clear pulse", int'(fco), 1);
        eq("R9 hold released", int'(hold), 0);
        eq("R9 busy kept", int'(busy), 1);
        n_clr++;
        @(negedge clk);
      end
      eq("R9 fast clear length", n_clr, FC);
      eq("R9 fast clear ended", int'(fco), 0);
      eq("R9 idle after clear", int'(busy), 0);
      eq("R9 no sample", int'(vld), 0);
    end else begin
      eq("R10 ignored in delay", int'(fco), 0);
      for (int n = at + 1; n <= d; n++) @(negedge clk);
      repeat (G) @(negedge clk);
      eq("R10 sequence continues", int'(vld), 1);
      eq("R10 token after ignored clear", int'(tok), 1);
      repeat (N * CH) @(negedge clk);
      eq("R10 sequence end", int'(busy), 0);
    end
  endtask

  task automatic finish_all;
    $display("%0d/%0d checks passed", pass_n, tot_n);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tot_n++;
    $display("FAIL watchdog: actual hung expected done");
    finish_all();
  end

  initial begin
    repeat (3) @(negedge clk);
    eq("R1 busy", int'(busy), 0);
    eq("R1 hold", int'(hold), 0);
    eq("R1 token", int'(tok), 0);
    eq("R1 clock", int'(fck), 0);
    eq("R1 valid", int'(vld), 0);
    eq("R1 fast clear", int'(fco), 0);
    eq("R1 test", int'(tst), 0);
    eq("R1 rejected", int'(rej), 0);
    rst_n = 1;
    @(negedge clk);
    treq = 1; #1;
    eq("R11 test when idle", int'(tst), 1);
    @(negedge clk); treq = 0; #1;
    eq("R11 test released", int'(tst), 0);
    for (int m = 0; m < (1 << N); m++)
      for (int di = 0; di < 3; di++)
        run(N'(m), (di == 0) ? 1 : (di == 1 ? 3 : 7), (m % 3) == 0);
    @(negedge clk); trig = 1; skip = 0; dly = 2;
    @(negedge clk); trig = 0; treq = 1; #1;
    eq("R11 test blocked while busy", int'(tst), 0);
    treq = 0;
    repeat (2 + G + N * CH + 2) @(negedge clk);
    abort(3, 4);
    abort(2, 4);
    abort(4, 2);
    run('0, 2, 1'b0);
    finish_all();
  end
endmodule